// File: doc/BRIEF.md
# DRAM ECC Error Log

This block sits beside the ECC checker of a DRAM controller that serves eight rows. The checker raises a single-bit strobe or a multi-bit strobe for each failing access. With the strobe it gives the physical address and the row index. The block keeps one sticky flag for each error class. It keeps the row of the first error of each class, and it keeps the failing address trimmed to its 4 KB page. No syndrome is kept or reported. Software reads these logs through a small register port and clears them by writing ones. A system-error level is raised for each class whose enable bit is set. The same port holds a 2-bit integrity mode: `00` none, `01` detect only, `10` correcting ECC, `11` correcting ECC with hardware scrub.

Each error class is tracked by its own two-state machine. In state `ST_CLEAR` no error of that class is held. In state `ST_LOGGED` one is held. Transition `ST_CLEAR -> ST_LOGGED` happens when an error of that class is accepted. Transition `ST_LOGGED -> ST_CLEAR` happens when software writes a 1 to that class's flag and no new error is accepted in the same cycle. Transition `ST_LOGGED -> ST_LOGGED`, with a new capture, happens when the flag is cleared and an error arrives in the same cycle. Any other cycle keeps the state. An error is accepted only when the mode is not `00`.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, all three registers read zero and `sys_err` is low.
- R2: Select `0` (page register) reads failing-address bits 31:12 at bits 31:12, the multi-bit flag at bit 1 and the single-bit flag at bit 0. Bits 11:2 read zero.
- R3: Select `1` (status register) reads the single-bit flag at bit 0, the single-bit row at bits 3:1, the multi-bit flag at bit 4 and the multi-bit row at bits 7:5. Bits 31:8 read zero.
- R4: A write to select `0` clears the single-bit flag when bit 0 is 1 and the multi-bit flag when bit 1 is 1. A write to select `1` clears the single-bit flag when bit 0 is 1 and the multi-bit flag when bit 4 is 1. Zero bits have no effect, and clearing leaves the row fields unchanged.
- R5: While a class's flag is set, further strobes of that class change neither its row field nor the captured page.
- R6: An accepted multi-bit error captures the page. An accepted single-bit error captures the page only if no multi-bit error is accepted in the same cycle and the multi-bit flag is not left set.
- R7: With mode `00`, strobes set no flag and capture nothing. Modes `01`, `10` and `11` all log errors.
- R8: `sys_err` is high exactly when (single-bit flag AND enable bit 0) OR (multi-bit flag AND enable bit 1).
- R9: Select `2` (command register) holds the single-bit enable at bit 0, the multi-bit enable at bit 1 and the mode at bits 3:2. It is written by a write to select `2` and reads back with all other bits zero. Select `3` reads zero.
- R10: A strobe that arrives in the same cycle as a clear of its class is logged, and its row and page are captured.
- R11: Register changes appear on `reg_rdata` and `sys_err` in the cycle after the clock edge that samples the strobe or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_strobe | input | 1 | Single-bit error seen this cycle |
| mbe_strobe | input | 1 | Multi-bit error seen this cycle |
| err_addr | input | 32 | Physical address of the failing access |
| sbe_row | input | 3 | Row of the single-bit error |
| mbe_row | input | 3 | Row of the multi-bit error |
| reg_sel | input | 2 | Register select: 0 page, 1 status, 2 command |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sys_err | output | 1 | System-error level |

## Verification
A state machine stuck in or out of `ST_LOGGED` shows up in the next cycle. The flag bits in both the page and status registers disagree with the expected ones, and so does `sys_err` when its enable is set. A wrong capture condition leaves a stale or overwritten page or row field, visible on the first read after the offending strobe. Random strobes, writes and mode changes are mixed with directed cases: same-cycle strobes of both classes, a strobe in the cycle of a clear, zero-bit writes and mode `00`.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
    typedef enum logic [1:0] {
        MODE_NONE    = 2'b00,
        MODE_DETECT  = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_SCRUB   = 2'b11
    } integ_mode_t;

    typedef enum logic {
        ST_CLEAR  = 1'b0,
        ST_LOGGED = 1'b1
    } class_state_t;

    localparam logic [1:0] SEL_PAGE   = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;
    localparam logic [1:0] SEL_CMD    = 2'd2;
endpackage

// File: rtl/ecclog_class_fsm.sv
module ecclog_class_fsm
    import ecclog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic log_en,
    input  logic strobe,
    input  logic clear,
    output logic logged,
    output logic accept
);
    class_state_t state_q, state_d;

    always_comb begin
        accept  = strobe && log_en && ((state_q == ST_CLEAR) || clear);
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:  if (accept) state_d = ST_LOGGED;
            ST_LOGGED: if (clear && !accept) state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    assign logged = (state_q == ST_LOGGED);

    // R5: a held flag stays held unless cleared
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (logged && !clear) |=> logged);
    // R4: a clear with no new error empties the flag
    p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !strobe) |=> !logged);
    // R7: without logging enabled no flag can rise
    p_no_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_en && !logged) |=> !logged);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecclog_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ROW_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_strobe,
    input  logic              mbe_strobe,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [ROW_W-1:0]  sbe_row,
    input  logic [ROW_W-1:0]  mbe_row,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              sys_err
);
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int ST_SF_BIT  = 0;
    localparam int ST_MF_BIT  = ROW_W + 1;
    localparam int STAT_W     = 2 * ROW_W + 2;
    localparam int CMD_W      = 4;

    logic [PAGE_W-1:0] page_q;
    logic [ROW_W-1:0]  srow_q, mrow_q;
    logic              en_sbe_q, en_mbe_q;
    integ_mode_t       mode_q;

    logic log_en, wr_page, wr_stat, wr_cmd;
    logic sbe_clr, mbe_clr;
    logic sbe_logged, mbe_logged, sbe_acc, mbe_acc;
    logic mbe_kept, sbe_takes_page;

    assign log_en  = (mode_q != MODE_NONE);
    assign wr_page = reg_wr && (reg_sel == SEL_PAGE);
    assign wr_stat = reg_wr && (reg_sel == SEL_STATUS);
    assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
    assign sbe_clr = (wr_page && reg_wdata[0]) || (wr_stat && reg_wdata[ST_SF_BIT]);
    assign mbe_clr = (wr_page && reg_wdata[1]) || (wr_stat && reg_wdata[ST_MF_BIT]);

    ecclog_class_fsm u_sbe_fsm (
        .clk(clk), .rst_n(rst_n), .log_en(log_en), .strobe(sbe_strobe),
        .clear(sbe_clr), .logged(sbe_logged), .accept(sbe_acc)
    );
    ecclog_class_fsm u_mbe_fsm (
        .clk(clk), .rst_n(rst_n), .log_en(log_en), .strobe(mbe_strobe),
        .clear(mbe_clr), .logged(mbe_logged), .accept(mbe_acc)
    );

    assign mbe_kept       = mbe_logged && !mbe_clr;
    assign sbe_takes_page = sbe_acc && !mbe_acc && !mbe_kept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            srow_q   <= '0;
            mrow_q   <= '0;
            en_sbe_q <= 1'b0;
            en_mbe_q <= 1'b0;
            mode_q   <= MODE_NONE;
        end else begin
            if (mbe_acc)             page_q <= err_addr[ADDR_W-1:PAGE_SHIFT];
            else if (sbe_takes_page) page_q <= err_addr[ADDR_W-1:PAGE_SHIFT];
            if (sbe_acc) srow_q <= sbe_row;
            if (mbe_acc) mrow_q <= mbe_row;
            if (wr_cmd) begin
                en_sbe_q <= reg_wdata[0];
                en_mbe_q <= reg_wdata[1];
                mode_q   <= integ_mode_t'(reg_wdata[3:2]);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_PAGE:   reg_rdata = {page_q, {(PAGE_SHIFT-2){1'b0}}, mbe_logged, sbe_logged};
            SEL_STATUS: reg_rdata = {{(ADDR_W-STAT_W){1'b0}}, mrow_q, mbe_logged, srow_q, sbe_logged};
            SEL_CMD:    reg_rdata = {{(ADDR_W-CMD_W){1'b0}}, mode_q, en_mbe_q, en_sbe_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign sys_err = (sbe_logged && en_sbe_q) || (mbe_logged && en_mbe_q);

    // R5 / R6: page frozen while the multi-bit flag is held
    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_logged && !mbe_clr) |=> $stable(page_q));
    // R5: single-bit row frozen while its flag is held
    p_srow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_logged && !sbe_clr) |=> $stable(srow_q));
    // R8: system error only with a flag set
    p_serr_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |-> (sbe_logged || mbe_logged));
    // R7: mode none never raises a flag
    p_mode_none_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NONE && !mbe_logged) |=> !mbe_logged);
endmodule

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sbe_strobe = 1'b0, mbe_strobe = 1'b0;
    logic [31:0] err_addr = '0;
    logic [2:0]  sbe_row = '0, mbe_row = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sys_err;

    ecc_err_log i_ecc_err_log (
        .clk(clk), .rst_n(rst_n), .sbe_strobe(sbe_strobe), .mbe_strobe(mbe_strobe),
        .err_addr(err_addr), .sbe_row(sbe_row), .mbe_row(mbe_row),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_err(sys_err)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    bit        m_sf, m_mf, m_es, m_em;
    bit [2:0]  m_sr, m_mr;
    bit [19:0] m_page;
    bit [1:0]  m_mode;

    function automatic logic [31:0] exp_rd(input logic [1:0] sel);
        case (sel)
            2'd0:    return {m_page, 10'd0, m_mf, m_sf};
            2'd1:    return {24'd0, m_mr, m_mf, m_sr, m_sf};
            2'd2:    return {28'd0, m_mode, m_em, m_es};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit exp_serr();
        return (m_sf && m_es) || (m_mf && m_em);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit s, input bit m, input logic [31:0] a,
                        input logic [2:0] sr, input logic [2:0] mr,
                        input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                        input string tag);
        bit sclr, mclr, sacc, macc, en;
        sbe_strobe = s; mbe_strobe = m; err_addr = a; sbe_row = sr; mbe_row = mr;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        en   = (m_mode != 2'b00);
        sclr = wr && ((sel == 2'd0 && wd[0]) || (sel == 2'd1 && wd[0]));
        mclr = wr && ((sel == 2'd0 && wd[1]) || (sel == 2'd1 && wd[4]));
        sacc = s && en && (!m_sf || sclr);
        macc = m && en && (!m_mf || mclr);
        @(posedge clk);
        #2;
        if (macc) m_page = a[31:12];
        else if (sacc && !(m_mf && !mclr)) m_page = a[31:12];
        if (sacc) m_sr = sr;
        if (macc) m_mr = mr;
        m_sf = sacc || (m_sf && !sclr);
        m_mf = macc || (m_mf && !mclr);
        if (wr && sel == 2'd2) begin
            m_es = wd[0]; m_em = wd[1]; m_mode = wd[3:2];
        end
        sbe_strobe = 0; mbe_strobe = 0; reg_wr = 0;
        #1;
        chk({tag, " R8 R11 sys_err"}, {31'd0, sys_err}, {31'd0, exp_serr()});
        chk({tag, " R11 rdata"}, reg_rdata, exp_rd(sel));
    endtask

    task automatic rd(input logic [1:0] sel, input string tag);
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata, exp_rd(sel));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        reg_sel = 2'd0; #1 chk("R1 page reset", reg_rdata, 32'd0);
        reg_sel = 2'd1; #1 chk("R1 status reset", reg_rdata, 32'd0);
        reg_sel = 2'd2; #1 chk("R1 cmd reset", reg_rdata, 32'd0);
        chk("R1 sys_err reset", {31'd0, sys_err}, 32'd0);

        // R7 mode none ignores strobes
        step(1, 1, 32'hDEAD_BEEF, 3'd2, 3'd6, 0, 2'd1, 0, "R7 none");
        chk("R7 status stays zero", reg_rdata, 32'd0);

        // R9 command write and readback
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFB, "R9 cmd");
        chk("R9 cmd literal", reg_rdata, 32'h0000_000B);
        rd(2'd3, "R9 sel3 zero");

        // R2 R3 single-bit capture
        step(1, 0, 32'h1234_5ABC, 3'd5, 3'd0, 0, 2'd0, 0, "R2 sbe");
        chk("R2 page literal", reg_rdata, 32'h1234_5001);
        rd(2'd1, "R3 status after sbe");
        chk("R3 status literal", reg_rdata, 32'h0000_000B);

        // R5 sticky single-bit
        step(1, 0, 32'hAAAA_A000, 3'd1, 3'd0, 0, 2'd1, 0, "R5 sbe held");
        rd(2'd0, "R5 page held");

        // R6 multi-bit takes page while sbe held
        step(0, 1, 32'h7777_7123, 3'd0, 3'd3, 0, 2'd0, 0, "R6 mbe page");
        chk("R6 page literal", reg_rdata, 32'h7777_7003);
        rd(2'd1, "R3 status both");

        // R4 zero write has no effect, then clear
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFC, "R4 zero bits");
        step(0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0001, "R4 clear sbe via status");
        step(1, 0, 32'h0BAD_0000, 3'd7, 0, 0, 2'd0, 0, "R6 sbe blocked by held mbe");
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0002, "R4 clear mbe via page");

        // R10 strobe in the clearing cycle
        step(1, 0, 32'h4444_4000, 3'd4, 0, 1, 2'd0, 32'h1, "R10 clear+strobe");
        rd(2'd1, "R10 row recaptured");

        // R6 both in same cycle
        step(0, 0, 0, 0, 0, 1, 2'd1, 32'h11, "R4 clear both");
        step(1, 1, 32'h9999_9000, 3'd1, 3'd2, 0, 2'd0, 0, "R6 same cycle");
        rd(2'd1, "R3 both rows");

        // R8 with enables off
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'h4, "R8 enables off");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit wr;
            logic [1:0] sel;
            logic [31:0] wd;
            wr  = ($urandom % 6) == 0;
            sel = 2'($urandom);
            wd  = $urandom;
            if (sel == 2'd2 && ($urandom % 4) != 0) wd[3:2] = 2'($urandom % 3 + 1);
            step(($urandom % 3) == 0, ($urandom % 3) == 0, $urandom, 3'($urandom),
                 3'($urandom), wr, sel, wd, "R4 R5 R6 R7 R10 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule